// File: doc/BRIEF.md
# Batched Disparity Job Controller

This block sequences one disparity-vector generation job. The host presents a triplet count on `total_count` and pulses `host_start`. The controller then loops through batches of at most `BATCH` triplets. For each batch it asks the loader to bring the triplets into local buffers. It then runs the processing units over those triplets and waits for them to write their results. Work on the next batch starts only after the current batch is finished.

Once every triplet has been handled, the controller asks the flush unit to copy the accumulated results to bulk memory. It then raises `host_done` and holds it until the host acknowledges. After that it returns to idle.

Each sub-unit receives a one-cycle start strobe and replies with a one-cycle done pulse. The sub-units generate their own internal sequencing. The processing units also get an enable level that covers the whole batch, and a clear strobe issued at the start of every batch.

Top module: `disp_job_ctrl`

## Requirements
- R1: After reset, and after a job ends, the controller issues no start strobe and keeps `host_done` low until `host_start` is sampled high.
- R2: Each batch begins with a single-cycle `load_start`. `proc_clear` is high in that same cycle, and `load_count` carries the size of the batch.
- R3: `proc_start` pulses for one cycle, in the cycle after `load_done` is sampled, and never before. `proc_en` is high from that cycle until `proc_done` is sampled, with the same `proc_count` as the load.
- R4: When triplets remain after `proc_done` is sampled, `proc_en` drops in the next cycle and the next `load_start` follows one cycle after that.
- R5: When no triplet remains after the last `proc_done` is sampled, `flush_start` pulses two cycles later. `flush_start` never appears while triplets are still pending.
- R6: `host_done` rises in the cycle after `flush_done` is sampled. It holds until `host_ack` is sampled and is low in the next cycle.
- R7: `total_count` is captured only at the accepted start. A `host_start`, or a change of `total_count`, while a job runs has no effect on the batch sequence.
- R8: Full batches carry `BATCH` (default 16) triplets. A final partial batch carries exactly the remainder, so the batch sizes add up to the captured count.
- R9: A job with a count of zero issues no load. `flush_start` pulses in the cycle after the start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_start | input | 1 | Job start request from the host |
| host_ack | input | 1 | Host acknowledge of job completion |
| total_count | input | CNT_W | Number of triplets in the job |
| load_start | output | 1 | Start strobe to the batch loader |
| load_count | output | BW | Triplets in the current batch |
| load_done | input | 1 | Loader finished the batch |
| proc_start | output | 1 | Start strobe to the processing units |
| proc_en | output | 1 | Processing enable, high during the batch |
| proc_clear | output | 1 | Clear strobe to the processing units |
| proc_count | output | BW | Triplets for the processing units |
| proc_done | input | 1 | Processing units finished the batch |
| flush_start | output | 1 | Start strobe to the result flush unit |
| flush_done | input | 1 | Flush unit finished |
| host_done | output | 1 | Job complete, held until acknowledged |

## Verification
Every accepted handshake moves the state register at one clock edge. The strobe of the new state is then visible in the following cycle. So `load_start` comes one cycle after the start, `proc_start` one cycle after `load_done`, and `host_done` one cycle after `flush_done`. The next load or the flush comes two cycles after `proc_done`, because the controller passes through a one-cycle bookkeeping state.

The bench drives inputs and samples outputs on the falling edge. It pulses each done for exactly one cycle and checks the expected strobe at the very next falling edge, or at the second one after `proc_done`. During the random waits in between, it checks that no strobe appears early.

// File: rtl/disp_job_ctrl.sv
module disp_job_ctrl #(
  parameter int BATCH = 16,
  parameter int CNT_W = 16,
  localparam int BW = $clog2(BATCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_start,
  input  logic             host_ack,
  input  logic [CNT_W-1:0] total_count,
  output logic             load_start,
  output logic [BW-1:0]    load_count,
  input  logic             load_done,
  output logic             proc_start,
  output logic             proc_en,
  output logic             proc_clear,
  output logic [BW-1:0]    proc_count,
  input  logic             proc_done,
  output logic             flush_start,
  input  logic             flush_done,
  output logic             host_done
);

  typedef enum logic [2:0] {IDLE, LOAD, PROC, NEXT, FLUSH, DONE} st_t;

  st_t             st, st_d;
  logic            first;
  logic [CNT_W-1:0] rem;
  logic [BW-1:0]   batch_n;

  assign batch_n = (rem >= CNT_W'(BATCH)) ? BW'(BATCH) : rem[BW-1:0];

  always_comb begin
    st_d = st;
    case (st)
      IDLE:  if (host_start) st_d = (total_count == '0) ? FLUSH : LOAD;
      LOAD:  if (load_done)  st_d = PROC;
      PROC:  if (proc_done)  st_d = NEXT;
      NEXT:  st_d = (rem == '0) ? FLUSH : LOAD;
      FLUSH: if (flush_done) st_d = DONE;
      DONE:  if (host_ack)   st_d = IDLE;
      default: st_d = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      first <= 1'b0;
      rem   <= '0;
    end else begin
      st    <= st_d;
      first <= (st_d != st);
      if (st == IDLE && host_start)
        rem <= total_count;
      else if (st == PROC && proc_done)
        rem <= rem - CNT_W'(batch_n);
    end
  end

  assign load_start  = (st == LOAD) && first;
  assign proc_clear  = load_start;
  assign proc_start  = (st == PROC) && first;
  assign proc_en     = (st == PROC);
  assign flush_start = (st == FLUSH) && first;
  assign host_done   = (st == DONE);
  assign load_count  = batch_n;
  assign proc_count  = batch_n;

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> !load_start); // R2
  AST_BATCH_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |-> (load_count != '0 && int'(load_count) <= BATCH)); // R8
  AST_PROC_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proc_en) |-> $past(load_done)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_start |-> rem == '0); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_done && !host_ack) |=> host_done); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_start, proc_start, flush_start})); // R1

endmodule

// File: tb/disp_job_ctrl_tb.sv
module disp_job_ctrl_tb;
  localparam int BATCH = 16;
  localparam int CNT_W = 16;
  localparam int BW = $clog2(BATCH + 1);

  logic clk = 0, rst_n = 0;
  logic host_start = 0, host_ack = 0, load_done = 0, proc_done = 0, flush_done = 0;
  logic [CNT_W-1:0] total_count = '0;
  logic load_start, proc_start, proc_en, proc_clear, flush_start, host_done;
  logic [BW-1:0] load_count, proc_count;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  disp_job_ctrl #(.BATCH(BATCH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_ack(host_ack),
    .total_count(total_count), .load_start(load_start), .load_count(load_count),
    .load_done(load_done), .proc_start(proc_start), .proc_en(proc_en),
    .proc_clear(proc_clear), .proc_count(proc_count), .proc_done(proc_done),
    .flush_start(flush_start), .flush_done(flush_done), .host_done(host_done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_batch(input int r);
    return (r >= BATCH) ? BATCH : r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle_quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!load_start && !proc_start && !flush_start && !host_done, "R1",
          {load_start, proc_start, flush_start, host_done}, 0);
    end
  endtask

  task automatic run_job(input int n);
    int rem = n;
    int sum = 0;
    int d;
    total_count = CNT_W'(n);
    host_start = 1;
    @(negedge clk);
    host_start = 0;
    total_count = CNT_W'($urandom_range(0, 200));
    if (n == 0) begin
      chk(flush_start == 1, "R9", flush_start, 1);
      chk(load_start == 0, "R9", load_start, 0);
    end
    while (rem > 0) begin
      chk(load_start == 1, "R2", load_start, 1);
      chk(proc_clear == 1, "R2", proc_clear, 1);
      chk(int'(load_count) == exp_batch(rem), "R8", load_count, exp_batch(rem));
      host_start = 1;
      @(negedge clk);
      host_start = 0;
      chk(!load_start && !proc_start, "R7", {load_start, proc_start}, 0);
      d = $urandom_range(0, 4);
      for (int i = 0; i < d; i++) begin
        @(negedge clk);
        chk(!proc_start && !proc_en && !load_start, "R3", {proc_start, proc_en, load_start}, 0);
      end
      load_done = 1;
      @(negedge clk);
      load_done = 0;
      chk(proc_start == 1 && proc_en == 1, "R3", {proc_start, proc_en}, 3);
      chk(int'(proc_count) == exp_batch(rem), "R3", proc_count, exp_batch(rem));
      d = $urandom_range(0, 5);
      for (int i = 0; i < d; i++) begin
        @(negedge clk);
        chk(proc_en && !proc_start && !load_start && !flush_start, "R3",
            {proc_en, proc_start, load_start, flush_start}, 8);
      end
      proc_done = 1;
      @(negedge clk);
      proc_done = 0;
      chk(proc_en == 0, "R4", proc_en, 0);
      chk(!flush_start && !load_start, "R5", {flush_start, load_start}, 0);
      sum += exp_batch(rem);
      rem -= exp_batch(rem);
      @(negedge clk);
      if (rem > 0) chk(load_start == 1, "R4", load_start, 1);
      else         chk(flush_start == 1 && load_start == 0, "R5", {flush_start, load_start}, 2);
    end
    chk(sum == n, "R8", sum, n);
    d = $urandom_range(0, 3);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk(host_done == 0, "R6", host_done, 0);
    end
    flush_done = 1;
    @(negedge clk);
    flush_done = 0;
    chk(host_done == 1, "R6", host_done, 1);
    d = $urandom_range(0, 4);
    for (int i = 0; i < d; i++) begin
      if (i == 0) host_start = 1;
      @(negedge clk);
      host_start = 0;
      chk(host_done == 1 && !load_start && !flush_start, "R6",
          {host_done, load_start, flush_start}, 4);
    end
    host_ack = 1;
    @(negedge clk);
    host_ack = 0;
    chk(host_done == 0, "R6", host_done, 0);
    idle_quiet(3);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!load_start && !proc_start && !flush_start && !host_done && !proc_en, "R1",
        {load_start, proc_start, flush_start, host_done, proc_en}, 0);
    rst_n = 1;
    idle_quiet(4);
    run_job(1);
    run_job(16);
    run_job(17);
    run_job(0);
    run_job(32);
    run_job(15);
    for (int j = 0; j < 12; j++) run_job($urandom_range(1, 70));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule